// File: doc/BRIEF.md
# D-PHY Data Lane Transmit Sequencer

This block drives one transmit data lane of a D-PHY style link. It produces the low-power P/N line levels and their output enables. It also produces a high-speed enable and a parallel byte for a downstream serializer. The protocol layer above it starts and ends high-speed bursts with a request/valid level and a ready handshake. Through escape mode it puts the lane into ultra-low-power state (ULPS) or sends low-power data bytes. A single lane state machine covers all of these functions. Every interval is counted in controller clock cycles and set by a parameter: `LPX_CYC` for each LP step, `ZERO_CYC` for the HS-zero bytes, `TRAIL_CYC` for the trail and `WAKE_CYC` for the ULPS wake-up mark.

Line levels are written {P,N} below. LP-11 means P=1 and N=1, LP-10 means P=1 and N=0, LP-01 means P=0 and N=1, and LP-00 means both low.

Top module: `dlane_tx_ctrl`

## Requirements
- R1: After reset, and whenever the lane idles, `stop_state` is 1, the line is LP-11, both LP output enables are 1, `hs_en` is 0 and `ulps_active_n` is 1.
- R2: When `hs_req` is high in stop state, the line shows LP-01 for `LPX_CYC` cycles, then LP-00 for `LPX_CYC` cycles, and then `hs_en` rises. While `hs_en` is high, both LP enables and both LP levels are 0.
- R3: While `hs_en` is high, `hs_byte` first carries `ZERO_CYC` bytes of 0x00, then one sync byte 0xB8, and then the accepted payload bytes in order.
- R4: `hs_ready` is high exactly in the cycles in which a payload byte is taken. In such a cycle `hs_byte` equals `hs_data`, and the number of ready cycles equals the number of bytes offered while `hs_req` is high.
- R5: Starting with the first cycle in which `hs_req` is low after the payload, `hs_byte` holds the trail byte for `TRAIL_CYC` cycles (`TRAIL_CYC` ≥ 2). Every bit of the trail byte is the inverse of bit 7 of the last accepted byte, which is the last bit serialized. After the trail, `hs_en` falls and the lane is in stop state with LP-11.
- R6: Escape entry starts when `esc_req` is high in stop state together with `esc_ulps` or `esc_lpdt`; `esc_ulps` wins if both are high. The line shows LP-10, LP-00, LP-01 and LP-00, each for `LPX_CYC` cycles. The command byte follows MSB first: 0x1E for ULPS and 0xE1 for LP data. Each bit is a mark of `LPX_CYC` cycles (LP-10 for a 1, LP-01 for a 0), followed by an LP-00 space of `LPX_CYC` cycles.
- R7: After the ULPS command the line stays at LP-00 with `ulps_active_n` = 0 and `stop_state` = 0.
- R8: A high `ulps_exit` in ULPS drives LP-10 for `WAKE_CYC` cycles with `ulps_active_n` still 0, then returns the lane to stop state with `ulps_active_n` = 1.
- R9: In LP data mode, a byte on `esc_data` with `esc_valid` high is captured from the idle LP-00 state. It is sent bit 0 first in the same mark/space form. `esc_ready` pulses for one cycle in the last cycle of the byte's final space, once per byte.
- R10: In LP data mode with `esc_valid` and `esc_req` both low, the lane drives LP-10 for `LPX_CYC` cycles and then returns to stop state.
- R11: An escape request has no effect while a high-speed burst runs. If `hs_req` and an escape request arrive together in stop state, the burst goes first. The escape entry begins one stop-state cycle after the trail ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hs_req | input | 1 | High-speed request and data valid |
| hs_data | input | 8 | High-speed payload byte |
| hs_ready | output | 1 | Payload byte taken this cycle |
| hs_en | output | 1 | High-speed driver enable |
| hs_byte | output | 8 | Parallel byte to the serializer |
| esc_req | input | 1 | Escape mode request |
| esc_ulps | input | 1 | Escape selects ULPS |
| esc_lpdt | input | 1 | Escape selects LP data transmission |
| esc_valid | input | 1 | Escape data byte valid |
| esc_data | input | 8 | Escape data byte, bit 0 sent first |
| esc_ready | output | 1 | Escape byte fully sent |
| ulps_exit | input | 1 | Leave ULPS |
| lp_p | output | 1 | LP level on the P wire |
| lp_n | output | 1 | LP level on the N wire |
| lp_p_oe | output | 1 | LP driver enable, P wire |
| lp_n_oe | output | 1 | LP driver enable, N wire |
| stop_state | output | 1 | Lane idles in stop state |
| ulps_active_n | output | 1 | Low while the lane is in ULPS |

## Verification
A high-speed request and an escape request can reach the stop state on the same clock edge. The bench provokes this by raising `hs_req` together with `esc_req` and `esc_ulps` at one negative edge, and it keeps the escape request high through the whole burst. The recorded line trace must show the complete HS entry and an unchanged byte stream. After the trail it must show exactly one LP-11 cycle, followed by the escape entry and the ULPS command, each compared run by run against sequences the bench builds from the requirements.

// File: rtl/dlt_pkg.sv
package dlt_pkg;

  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] SYNC_BYTE = 8'hB8;
  localparam logic [BYTE_W-1:0] CMD_ULPS  = 8'h1E;
  localparam logic [BYTE_W-1:0] CMD_LPDT  = 8'hE1;

  // LP line level, {P,N}
  typedef logic [1:0] lp_line_t;
  localparam lp_line_t LN_11 = 2'b11;
  localparam lp_line_t LN_10 = 2'b10;
  localparam lp_line_t LN_01 = 2'b01;
  localparam lp_line_t LN_00 = 2'b00;

  typedef enum logic [4:0] {
    S_STOP,
    S_HRQ,
    S_HPRE,
    S_HZERO,
    S_HSYNC,
    S_HDATA,
    S_HTRAIL,
    S_EE0,
    S_EE1,
    S_EE2,
    S_EE3,
    S_MARK,
    S_SPACE,
    S_ULPS,
    S_WAKE,
    S_LIDLE,
    S_EEXIT
  } lane_st_e;

  typedef enum logic [1:0] {
    M_ULPS,
    M_LPDT,
    M_DATA
  } esc_mode_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dlt_rst_sync.sv
module dlt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_ns = sync_q[1];

endmodule

// File: rtl/dlt_timer.sv
module dlt_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] val,
  output logic         done
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = ld || (cnt_q != '0);
    cnt_d  = ld ? val : (cnt_q - W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/dlt_shifter.sv
module dlt_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [DW-1:0] val,
  input  logic          adv,
  output logic          bit_o,
  output logic          last_o
);

  localparam int IW = (DW > 1) ? $clog2(DW) : 1;

  logic [DW-1:0] sh_q;
  logic [IW-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      idx_q <= '0;
    end else if (ld) begin
      sh_q  <= val;
      idx_q <= '0;
    end else if (adv) begin
      sh_q  <= {1'b0, sh_q[DW-1:1]};
      idx_q <= idx_q + IW'(1);
    end
  end

  assign bit_o  = sh_q[0];
  assign last_o = (idx_q == IW'(DW-1));

endmodule

// File: rtl/dlane_tx_ctrl.sv
module dlane_tx_ctrl
  import dlt_pkg::*;
#(
  parameter int LPX_CYC   = 2,
  parameter int ZERO_CYC  = 4,
  parameter int TRAIL_CYC = 3,
  parameter int WAKE_CYC  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hs_req,
  input  logic [BYTE_W-1:0] hs_data,
  output logic              hs_ready,
  output logic              hs_en,
  output logic [BYTE_W-1:0] hs_byte,
  input  logic              esc_req,
  input  logic              esc_ulps,
  input  logic              esc_lpdt,
  input  logic              esc_valid,
  input  logic [BYTE_W-1:0] esc_data,
  output logic              esc_ready,
  input  logic              ulps_exit,
  output logic              lp_p,
  output logic              lp_n,
  output logic              lp_p_oe,
  output logic              lp_n_oe,
  output logic              stop_state,
  output logic              ulps_active_n
);

  localparam int MAX_CYC = max2(max2(LPX_CYC, ZERO_CYC), max2(TRAIL_CYC, WAKE_CYC));
  localparam int TMR_W   = $clog2(MAX_CYC + 1);

  localparam logic [TMR_W-1:0] LPX_M1   = TMR_W'(LPX_CYC - 1);
  localparam logic [TMR_W-1:0] ZERO_M1  = TMR_W'(ZERO_CYC - 1);
  localparam logic [TMR_W-1:0] TRAIL_M2 = TMR_W'(TRAIL_CYC - 2);
  localparam logic [TMR_W-1:0] WAKE_M1  = TMR_W'(WAKE_CYC - 1);

  logic rst_ns;

  lane_st_e  st_q, st_nx;
  esc_mode_e mode_q, mode_nx;

  logic              tmr_ld;
  logic [TMR_W-1:0]  tmr_val;
  logic              tmr_done;
  logic              sh_ld;
  logic [BYTE_W-1:0] sh_val;
  logic              sh_adv;
  logic              sh_bit;
  logic              sh_last;
  logic              last_bit_q;
  logic              last_bit_en;
  logic              last_bit_d;
  lp_line_t          line;

  // commands go out MSB first through an LSB-first shifter: load them mirrored
  logic [BYTE_W-1:0] ulps_cmd_rev;
  logic [BYTE_W-1:0] lpdt_cmd_rev;

  for (genvar g = 0; g < BYTE_W; g++) begin : g_cmd_rev
    assign ulps_cmd_rev[g] = CMD_ULPS[BYTE_W-1-g];
    assign lpdt_cmd_rev[g] = CMD_LPDT[BYTE_W-1-g];
  end

  dlt_rst_sync u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  dlt_timer #(.W(TMR_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_ns),
    .ld    (tmr_ld),
    .val   (tmr_val),
    .done  (tmr_done)
  );

  dlt_shifter #(.DW(BYTE_W)) u_shifter (
    .clk    (clk),
    .rst_n  (rst_ns),
    .ld     (sh_ld),
    .val    (sh_val),
    .adv    (sh_adv),
    .bit_o  (sh_bit),
    .last_o (sh_last)
  );

  // next-state logic
  always_comb begin
    st_nx   = st_q;
    mode_nx = mode_q;
    tmr_ld  = 1'b0;
    tmr_val = LPX_M1;
    sh_ld   = 1'b0;
    sh_val  = esc_data;
    sh_adv  = 1'b0;
    unique case (st_q)
      S_STOP: begin
        if (hs_req) begin
          st_nx  = S_HRQ;
          tmr_ld = 1'b1;
        end else if (esc_req && (esc_ulps || esc_lpdt)) begin
          st_nx   = S_EE0;
          tmr_ld  = 1'b1;
          mode_nx = esc_ulps ? M_ULPS : M_LPDT;
        end
      end
      S_HRQ: begin
        if (tmr_done) begin
          st_nx  = S_HPRE;
          tmr_ld = 1'b1;
        end
      end
      S_HPRE: begin
        if (tmr_done) begin
          st_nx   = S_HZERO;
          tmr_ld  = 1'b1;
          tmr_val = ZERO_M1;
        end
      end
      S_HZERO: begin
        if (tmr_done) begin
          st_nx = S_HSYNC;
        end
      end
      S_HSYNC: begin
        st_nx = S_HDATA;
      end
      S_HDATA: begin
        if (!hs_req) begin
          st_nx   = S_HTRAIL;
          tmr_ld  = 1'b1;
          tmr_val = TRAIL_M2;
        end
      end
      S_HTRAIL: begin
        if (tmr_done) begin
          st_nx = S_STOP;
        end
      end
      S_EE0: begin
        if (tmr_done) begin
          st_nx  = S_EE1;
          tmr_ld = 1'b1;
        end
      end
      S_EE1: begin
        if (tmr_done) begin
          st_nx  = S_EE2;
          tmr_ld = 1'b1;
        end
      end
      S_EE2: begin
        if (tmr_done) begin
          st_nx  = S_EE3;
          tmr_ld = 1'b1;
        end
      end
      S_EE3: begin
        if (tmr_done) begin
          st_nx  = S_MARK;
          tmr_ld = 1'b1;
          sh_ld  = 1'b1;
          sh_val = (mode_q == M_ULPS) ? ulps_cmd_rev : lpdt_cmd_rev;
        end
      end
      S_MARK: begin
        if (tmr_done) begin
          st_nx  = S_SPACE;
          tmr_ld = 1'b1;
        end
      end
      S_SPACE: begin
        if (tmr_done) begin
          if (!sh_last) begin
            st_nx  = S_MARK;
            tmr_ld = 1'b1;
            sh_adv = 1'b1;
          end else if (mode_q == M_ULPS) begin
            st_nx = S_ULPS;
          end else begin
            st_nx = S_LIDLE;
          end
        end
      end
      S_ULPS: begin
        if (ulps_exit) begin
          st_nx   = S_WAKE;
          tmr_ld  = 1'b1;
          tmr_val = WAKE_M1;
        end
      end
      S_WAKE: begin
        if (tmr_done) begin
          st_nx = S_STOP;
        end
      end
      S_LIDLE: begin
        if (esc_valid) begin
          st_nx   = S_MARK;
          tmr_ld  = 1'b1;
          sh_ld   = 1'b1;
          mode_nx = M_DATA;
        end else if (!esc_req) begin
          st_nx  = S_EEXIT;
          tmr_ld = 1'b1;
        end
      end
      S_EEXIT: begin
        if (tmr_done) begin
          st_nx = S_STOP;
        end
      end
      default: begin
        st_nx = S_STOP;
      end
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      st_q   <= S_STOP;
      mode_q <= M_ULPS;
    end else begin
      st_q   <= st_nx;
      mode_q <= mode_nx;
    end
  end

  // last serialized bit of the HS stream, source of the trail level
  always_comb begin
    last_bit_en = (st_q == S_HSYNC) || hs_ready;
    last_bit_d  = (st_q == S_HSYNC) ? SYNC_BYTE[BYTE_W-1] : hs_data[BYTE_W-1];
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      last_bit_q <= 1'b0;
    end else if (last_bit_en) begin
      last_bit_q <= last_bit_d;
    end
  end

  // outputs
  always_comb begin
    unique case (st_q)
      S_STOP:  line = LN_11;
      S_HRQ:   line = LN_01;
      S_EE0:   line = LN_10;
      S_EE2:   line = LN_01;
      S_MARK:  line = sh_bit ? LN_10 : LN_01;
      S_WAKE:  line = LN_10;
      S_EEXIT: line = LN_10;
      default: line = LN_00;
    endcase
  end

  always_comb begin
    unique case (st_q)
      S_HZERO:  hs_byte = '0;
      S_HSYNC:  hs_byte = SYNC_BYTE;
      S_HDATA:  hs_byte = hs_req ? hs_data : {BYTE_W{~last_bit_q}};
      S_HTRAIL: hs_byte = {BYTE_W{~last_bit_q}};
      default:  hs_byte = '0;
    endcase
  end

  assign hs_en = (st_q == S_HZERO) || (st_q == S_HSYNC) ||
                 (st_q == S_HDATA) || (st_q == S_HTRAIL);
  assign hs_ready      = (st_q == S_HDATA) && hs_req;
  assign esc_ready     = (st_q == S_SPACE) && tmr_done && sh_last && (mode_q == M_DATA);
  assign lp_p          = line[1];
  assign lp_n          = line[0];
  assign lp_p_oe       = !hs_en;
  assign lp_n_oe       = !hs_en;
  assign stop_state    = (st_q == S_STOP);
  assign ulps_active_n = !((st_q == S_ULPS) || (st_q == S_WAKE));

endmodule

// File: rtl/dlt_checker.sv
module dlt_checker (
  input logic clk,
  input logic rst_n,
  input logic hs_req,
  input logic hs_ready,
  input logic hs_en,
  input logic esc_ready,
  input logic lp_p,
  input logic lp_n,
  input logic lp_p_oe,
  input logic lp_n_oe,
  input logic stop_state,
  input logic ulps_active_n
);

  assert_stop_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_state |-> (lp_p && lp_n && !hs_en && lp_p_oe && lp_n_oe && ulps_active_n));

  assert_hs_after_prep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_en) |-> ($past(!lp_p) && $past(!lp_n) && $past(!stop_state)));

  assert_hs_lp_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hs_en |-> (!lp_p && !lp_n));

  assert_ready_in_burst_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hs_ready |-> (hs_en && hs_req));

  assert_ulps_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ulps_active_n |-> (!lp_n && !stop_state && !hs_en));

  assert_wake_to_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ulps_active_n) |-> (stop_state && $past(lp_p) && $past(!lp_n)));

  assert_esc_ready_space_R9: assert property (@(posedge clk) disable iff (!rst_n)
    esc_ready |-> (!hs_en && !lp_p && !lp_n && ulps_active_n));

  assert_esc_ready_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    esc_ready |=> !esc_ready);

  assert_hs_excludes_esc_R11: assert property (@(posedge clk) disable iff (!rst_n)
    hs_en |-> (ulps_active_n && !esc_ready));

endmodule

bind dlane_tx_ctrl dlt_checker u_dlt_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .hs_req        (hs_req),
  .hs_ready      (hs_ready),
  .hs_en         (hs_en),
  .esc_ready     (esc_ready),
  .lp_p          (lp_p),
  .lp_n          (lp_n),
  .lp_p_oe       (lp_p_oe),
  .lp_n_oe       (lp_n_oe),
  .stop_state    (stop_state),
  .ulps_active_n (ulps_active_n)
);

// File: tb/test_dlane_tx_ctrl.sv
module test_dlane_tx_ctrl;

  localparam int LPX   = 3;
  localparam int ZERO  = 5;
  localparam int TRAIL = 4;
  localparam int WAKE  = 7;
  localparam int MAXR  = 1024;

  localparam logic [2:0] C11 = 3'b011;
  localparam logic [2:0] C10 = 3'b010;
  localparam logic [2:0] C01 = 3'b001;
  localparam logic [2:0] C00 = 3'b000;
  localparam logic [2:0] CHS = 3'b100;

  logic       clk;
  logic       rst_n;
  logic       hs_req;
  logic [7:0] hs_data;
  logic       hs_ready;
  logic       hs_en;
  logic [7:0] hs_byte;
  logic       esc_req;
  logic       esc_ulps;
  logic       esc_lpdt;
  logic       esc_valid;
  logic [7:0] esc_data;
  logic       esc_ready;
  logic       ulps_exit;
  logic       lp_p;
  logic       lp_n;
  logic       lp_p_oe;
  logic       lp_n_oe;
  logic       stop_state;
  logic       ulps_active_n;

  dlane_tx_ctrl #(
    .LPX_CYC   (LPX),
    .ZERO_CYC  (ZERO),
    .TRAIL_CYC (TRAIL),
    .WAKE_CYC  (WAKE)
  ) i_dlane_tx_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .hs_req        (hs_req),
    .hs_data       (hs_data),
    .hs_ready      (hs_ready),
    .hs_en         (hs_en),
    .hs_byte       (hs_byte),
    .esc_req       (esc_req),
    .esc_ulps      (esc_ulps),
    .esc_lpdt      (esc_lpdt),
    .esc_valid     (esc_valid),
    .esc_data      (esc_data),
    .esc_ready     (esc_ready),
    .ulps_exit     (ulps_exit),
    .lp_p          (lp_p),
    .lp_n          (lp_n),
    .lp_p_oe       (lp_p_oe),
    .lp_n_oe       (lp_n_oe),
    .stop_state    (stop_state),
    .ulps_active_n (ulps_active_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk;
  int n_fail;

  // recorded trace
  bit         rec;
  logic [2:0] rc [MAXR];
  int         rl [MAXR];
  int         nr;
  logic [7:0] bg [MAXR];
  int         nb;
  int         hr_cnt;
  int         er_cnt;
  int         wake_cnt;

  // expected trace
  logic [2:0] ec [MAXR];
  int         el [MAXR];
  int         ne;
  logic [7:0] eb [MAXR];
  int         neb;

  logic [7:0] pay [64];

  always @(negedge clk) begin
    logic [2:0] code;
    #1;
    if (rec && nr < MAXR && nb < MAXR) begin
      code = hs_en ? CHS : {1'b0, lp_p, lp_n};
      if (nr == 0 || code != rc[nr-1]) begin
        rc[nr] = code;
        rl[nr] = 1;
        nr++;
      end else begin
        rl[nr-1]++;
      end
      if (hs_en) begin
        bg[nb] = hs_byte;
        nb++;
      end
      if (hs_ready) hr_cnt++;
      if (esc_ready) er_cnt++;
      if (lp_p && !lp_n && !ulps_active_n) wake_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic start_rec();
    rec = 1'b0;
    nr = 0; nb = 0; hr_cnt = 0; er_cnt = 0; wake_cnt = 0;
    ne = 0; neb = 0;
    rec = 1'b1;
  endtask

  task automatic push(input logic [2:0] c, input int l);
    ec[ne] = c;
    el[ne] = l;
    ne++;
  endtask

  task automatic push_byte(input logic [7:0] b);
    eb[neb] = b;
    neb++;
  endtask

  // spaced one-hot bit: mark then space (space length 0 = any)
  task automatic push_bit(input bit b, input int space_len);
    push(b ? C10 : C01, LPX);
    push(C00, space_len);
  endtask

  task automatic push_esc_entry();
    push(C10, LPX); push(C00, LPX); push(C01, LPX); push(C00, LPX);
  endtask

  task automatic push_cmd(input logic [7:0] cmd);
    for (int i = 7; i >= 0; i--) push_bit(cmd[i], (i == 0) ? 0 : LPX);
  endtask

  task automatic check_runs(input string req);
    int bad;
    bad = -1;
    if (nr != ne) bad = (nr < ne) ? nr : ne;
    for (int i = 0; i < ne && i < nr; i++) begin
      if (bad < 0 && (rc[i] != ec[i] || (el[i] != 0 && rl[i] != el[i]))) bad = i;
    end
    if (bad < 0) begin
      chk(1'b1, req, "line runs", 0, 0);
    end else if (bad < nr && bad < ne) begin
      chk(1'b0, req, $sformatf("run %0d code*1000+len", bad),
          int'(rc[bad]) * 1000 + rl[bad], int'(ec[bad]) * 1000 + el[bad]);
    end else begin
      chk(1'b0, req, "number of line runs", nr, ne);
    end
  endtask

  task automatic check_bytes(input string req);
    int bad;
    bad = -1;
    for (int i = 0; i < neb && i < nb; i++) begin
      if (bad < 0 && bg[i] != eb[i]) bad = i;
    end
    if (nb != neb) chk(1'b0, req, "hs byte count", nb, neb);
    else if (bad >= 0) chk(1'b0, req, $sformatf("hs byte %0d", bad), int'(bg[bad]), int'(eb[bad]));
    else chk(1'b1, req, "hs bytes", 0, 0);
  endtask

  task automatic wait_stop();
    do begin
      @(negedge clk);
      #2;
    end while (!stop_state);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // drive one burst of n bytes held in pay[]
  task automatic hs_burst(input int n, input bit with_esc);
    int i;
    @(negedge clk);
    hs_req  = 1'b1;
    hs_data = pay[0];
    if (with_esc) begin
      esc_req  = 1'b1;
      esc_ulps = 1'b1;
    end
    i = 0;
    while (i < n) begin
      #1;
      if (hs_ready) i++;
      @(negedge clk);
      if (i < n) hs_data = pay[i];
    end
    hs_req  = 1'b0;
    hs_data = $urandom();
  endtask

  task automatic expect_hs(input int n);
    push(C11, 0); push(C01, LPX); push(C00, LPX);
    push(CHS, ZERO + 1 + n + TRAIL);
    for (int i = 0; i < ZERO; i++) push_byte(8'h00);
    push_byte(8'hB8);
    for (int i = 0; i < n; i++) push_byte(pay[i]);
    for (int i = 0; i < TRAIL; i++) push_byte(pay[n-1][7] ? 8'h00 : 8'hFF);
  endtask

  task automatic run_hs(input int n, input bit force_last, input logic [7:0] last_v);
    for (int i = 0; i < n; i++) pay[i] = 8'($urandom());
    if (force_last) pay[n-1] = last_v;
    start_rec();
    hs_burst(n, 1'b0);
    wait_stop();
    idle(2);
    rec = 1'b0;
    expect_hs(n);
    push(C11, 0);
    check_runs("R2 hs entry");
    check_bytes("R3 R5 zero sync payload trail");
    chk(hr_cnt == n, "R4", "hs_ready cycles", hr_cnt, n);
    chk(stop_state && lp_p && lp_n && !hs_en, "R5", "stop after trail",
        {stop_state, lp_p, lp_n, hs_en}, 4'b1110);
  endtask

  task automatic run_lpdt(input int n);
    logic [7:0] b [4];
    int i;
    for (int k = 0; k < n; k++) b[k] = 8'($urandom());
    start_rec();
    @(negedge clk);
    esc_req   = 1'b1;
    esc_lpdt  = 1'b1;
    esc_valid = 1'b1;
    esc_data  = b[0];
    i = 0;
    while (i < n) begin
      #1;
      if (esc_ready) i++;
      @(negedge clk);
      if (i < n) esc_data = b[i];
    end
    esc_valid = 1'b0;
    esc_req   = 1'b0;
    esc_lpdt  = 1'b0;
    wait_stop();
    idle(2);
    rec = 1'b0;
    push(C11, 0);
    push_esc_entry();
    push_cmd(8'hE1);
    for (int k = 0; k < n; k++) begin
      for (int j = 0; j < 8; j++) push_bit(b[k][j], (j == 7) ? 0 : LPX);
    end
    push(C10, LPX);
    push(C11, 0);
    check_runs("R6 R9 R10 lp data trace");
    chk(er_cnt == n, "R9", "esc_ready pulses", er_cnt, n);
    chk(nb == 0, "R9", "hs cycles during lp data", nb, 0);
  endtask

  initial begin
    int seed_d;
    seed_d = $urandom(32'd1357);
    n_chk = 0; n_fail = 0; rec = 1'b0;
    rst_n = 1'b0;
    hs_req = 1'b0; hs_data = 8'h00;
    esc_req = 1'b0; esc_ulps = 1'b0; esc_lpdt = 1'b0;
    esc_valid = 1'b0; esc_data = 8'h00; ulps_exit = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    #1;
    // R1 reset state
    chk(stop_state == 1'b1, "R1", "stop_state after reset", stop_state, 1);
    chk(lp_p && lp_n && lp_p_oe && lp_n_oe, "R1", "LP-11 driven after reset",
        {lp_p, lp_n, lp_p_oe, lp_n_oe}, 4'b1111);
    chk(!hs_en && ulps_active_n && !hs_ready && !esc_ready, "R1", "idle flags",
        {hs_en, ulps_active_n, hs_ready, esc_ready}, 4'b0100);

    // R2-R5 directed trail polarity, then random bursts
    run_hs(1, 1'b1, 8'h80);
    run_hs(3, 1'b1, 8'h7F);
    for (int t = 0; t < 4; t++) run_hs(1 + int'($urandom_range(0, 11)), 1'b0, 8'h00);

    // R11: burst and ULPS escape requested on the same edge
    for (int i = 0; i < 4; i++) pay[i] = 8'($urandom());
    start_rec();
    hs_burst(4, 1'b1);
    do begin
      @(negedge clk);
      #2;
    end while (ulps_active_n);
    idle(3);
    #2;
    rec = 1'b0;
    expect_hs(4);
    push(C11, 1);
    push_esc_entry();
    push_cmd(8'h1E);
    check_runs("R11 R6 hs first then escape");
    check_bytes("R11 burst unaffected by escape request");
    // R7 ULPS state
    chk(!ulps_active_n && !stop_state && !lp_p && !lp_n, "R7", "ulps status",
        {ulps_active_n, stop_state, lp_p, lp_n}, 0);
    esc_req = 1'b0;
    esc_ulps = 1'b0;
    idle(3);
    #2;
    chk(!ulps_active_n && !stop_state, "R7", "ulps held after request drop",
        {ulps_active_n, stop_state}, 0);

    // R8 exit
    start_rec();
    @(negedge clk);
    ulps_exit = 1'b1;
    @(negedge clk);
    ulps_exit = 1'b0;
    wait_stop();
    idle(2);
    rec = 1'b0;
    push(C00, 0); push(C10, WAKE); push(C11, 0);
    check_runs("R8 wake mark");
    chk(wake_cnt == WAKE, "R8", "cycles LP-10 with ulps_active_n low", wake_cnt, WAKE);
    chk(ulps_active_n && stop_state, "R8", "back in stop", {ulps_active_n, stop_state}, 3);

    // R9 R10 LP data
    run_lpdt(1);
    run_lpdt(1 + int'($urandom_range(1, 2)));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule